// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a direct-mapped data cache that sits between a processor-side request port and a memory-side port. Each 32-bit word address is split into a byte offset, a word select, a line index and a tag. Every line holds a valid flag, a dirty flag, a stored tag and a block of four 32-bit words. A request is taken when the controller is idle. It is looked up in the following cycle, and it is either completed as a hit or handled as a miss that replaces the indexed line.

Stores go only into the cache and mark the line dirty. Memory is updated only when a dirty line is displaced. A displaced dirty block is placed in a small write buffer that empties to memory in word beats on its own handshake, so the refill of the new block does not wait for the writeback. The controller stalls only when it must displace a dirty block while the buffer is full. A miss to a block that is still held in the buffer is refilled from the buffer and makes no memory read.

Top module: `dwb_cache`

## Requirements
- R1: After reset every line is invalid and no line is dirty. `req_ready` is 1 and `rsp_valid`, `mem_rd_valid` and `mem_wvalid` are 0. The first access to any address after reset is a miss.
- R2: Address fields are as follows: bits [1:0] are the byte offset, bits [3:2] select the word within the block, bits [6:4] are the line index (block address modulo 8) and bits [31:7] are the tag. Two addresses with the same index and different tags compete for one line. Addresses in the same block share it.
- R3: A lookup on an invalid line is a miss even when the stored tag equals the address tag. Stored tags reset to 0, so address 0 right after reset is a miss.
- R4: A hit raises `rsp_valid` in the cycle after the request is accepted, with the addressed word on `rsp_rdata` for a read. A hit makes no memory traffic.
- R5: A miss that is not served from the write buffer issues exactly one read request with the block-aligned address. It then takes four `mem_rvalid` beats in ascending word order, installs the block clean and completes the access.
- R6: A store updates only the cached word and sets the line dirty. A store hit produces no memory write.
- R7: A miss that displaces a valid dirty line pushes the old block into the write buffer. The buffer writes it to memory as four beats with word addresses ascending from the block base, and `mem_wlast` is set on the fourth beat. A clean or invalid victim is never written back.
- R8: A store hit takes two cycles: it is accepted, then acknowledged with `rsp_valid` in the next cycle, and `req_ready` is 0 in that second cycle.
- R9: The controller stalls only when a dirty victim must be pushed while the write buffer is full. A miss with a clean victim proceeds while the buffer is full.
- R10: A miss to a block held in the write buffer is refilled from the youngest matching buffer entry without a memory read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can take a request this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Access completes this cycle |
| rsp_rdata | output | 32 | Load data |
| mem_rd_valid | output | 1 | Block read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Block-aligned read address |
| mem_rvalid | input | 1 | Refill word beat present |
| mem_rdata | input | 32 | Refill word |
| mem_wvalid | output | 1 | Writeback word beat present |
| mem_wready | input | 1 | Memory accepts the writeback beat |
| mem_waddr | output | 32 | Word address of the writeback beat |
| mem_wdata | output | 32 | Writeback word |
| mem_wlast | output | 1 | Last beat of a writeback block |

## Verification
The stalled eviction and the last drain beat of the write buffer can fall in the same cycle. The pop that frees a slot coincides with the state in which the waiting dirty victim is pushed. The bench provokes this by holding `mem_wready` low until two dirty blocks fill the buffer, then starting a third dirty eviction and checking that it neither completes nor reads memory. When the drain is released, the stalled access must return the correct word, and memory must end up with twelve writeback beats carrying the three stored values. A refill served from the buffer while the buffer is full is judged in the same run by a read-request count that does not change.

// File: rtl/dwbc_pkg.sv
package dwbc_pkg;

    // Default geometry of the cache
    localparam int DEF_ADDR_W  = 32;
    localparam int DEF_DATA_W  = 32;
    localparam int DEF_LINES   = 8;
    localparam int DEF_WORDS   = 4;
    localparam int DEF_WBDEPTH = 2;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a request
        ST_LOOK = 2'd1,   // tag compare, hit completion or miss decision
        ST_MREQ = 2'd2,   // block read request on the memory port
        ST_FILL = 2'd3    // collecting refill beats
    } ctrl_st_e;

endpackage

// File: rtl/dwbc_line_store.sv
module dwbc_line_store #(
    parameter  int LINES  = 8,
    parameter  int WORDS  = 4,
    parameter  int DATA_W = 32,
    parameter  int TAG_W  = 25,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int LINE_W = WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line
);

    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINE_W-1:0] data_q [LINES];

    // Per-line state flags and tags
    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic sel;
        assign sel = (idx == IDX_W'(l));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[l] <= 1'b0;
                dirty_q[l] <= 1'b0;
                tag_q[l]   <= '0;
            end else if (sel && fill_en) begin
                valid_q[l] <= 1'b1;
                dirty_q[l] <= 1'b0;
                tag_q[l]   <= fill_tag;
            end else if (sel && wr_en) begin
                dirty_q[l] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel && fill_en) begin
                data_q[l] <= fill_line;
            end else if (sel && wr_en) begin
                data_q[l][wr_sel*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end

    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_q[idx];
    assign rd_line  = data_q[idx];

endmodule

// File: rtl/dwbc_wbuf.sv
module dwbc_wbuf #(
    parameter  int ADDR_W  = 32,
    parameter  int DATA_W  = 32,
    parameter  int WORDS   = 4,
    parameter  int DEPTH   = 2,
    localparam int BYTE_W  = $clog2(DATA_W / 8),
    localparam int WSEL_W  = $clog2(WORDS),
    localparam int BADDR_W = ADDR_W - BYTE_W - WSEL_W,
    localparam int LINE_W  = WORDS * DATA_W,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push,
    input  logic [BADDR_W-1:0] push_baddr,
    input  logic [LINE_W-1:0]  push_line,
    output logic               full,
    input  logic [BADDR_W-1:0] lk_baddr,
    output logic               lk_hit,
    output logic [LINE_W-1:0]  lk_line,
    output logic               mem_wvalid,
    input  logic               mem_wready,
    output logic [ADDR_W-1:0]  mem_waddr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               mem_wlast
);

    logic [BADDR_W-1:0] ent_baddr [DEPTH];
    logic [LINE_W-1:0]  ent_line  [DEPTH];
    logic [PTR_W-1:0]   rd_ptr, wr_ptr, slot;
    logic [CNT_W-1:0]   count;
    logic [WSEL_W-1:0]  beat;
    logic               beat_go, pop;

    assign full       = (count == CNT_W'(DEPTH));
    assign mem_wvalid = (count != '0);
    assign mem_wlast  = (beat == WSEL_W'(WORDS - 1));
    assign mem_wdata  = ent_line[rd_ptr][beat*DATA_W +: DATA_W];
    assign mem_waddr  = {ent_baddr[rd_ptr], beat, BYTE_W'(0)};
    assign beat_go    = mem_wvalid && mem_wready;
    assign pop        = beat_go && mem_wlast;

    // Youngest matching entry wins: scan from oldest to newest
    always_comb begin
        lk_hit  = 1'b0;
        lk_line = '0;
        slot    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            slot = rd_ptr + PTR_W'(i);
            if (CNT_W'(i) < count && ent_baddr[slot] == lk_baddr) begin
                lk_hit  = 1'b1;
                lk_line = ent_line[slot];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            beat   <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            if (beat_go) beat <= mem_wlast ? '0 : beat + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            ent_baddr[wr_ptr] <= push_baddr;
            ent_line[wr_ptr]  <= push_line;
        end
    end

endmodule

// File: rtl/dwbc_ctrl.sv
module dwbc_ctrl
    import dwbc_pkg::*;
#(
    parameter  int ADDR_W  = 32,
    parameter  int DATA_W  = 32,
    parameter  int LINES   = 8,
    parameter  int WORDS   = 4,
    localparam int BYTE_W  = $clog2(DATA_W / 8),
    localparam int WSEL_W  = $clog2(WORDS),
    localparam int OFF_W   = BYTE_W + WSEL_W,
    localparam int IDX_W   = $clog2(LINES),
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
    localparam int BADDR_W = ADDR_W - OFF_W,
    localparam int LINE_W  = WORDS * DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_we,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [IDX_W-1:0]   ls_idx,
    input  logic               ls_valid,
    input  logic               ls_dirty,
    input  logic [TAG_W-1:0]   ls_tag,
    input  logic [LINE_W-1:0]  ls_line,
    output logic               ls_wr_en,
    output logic [WSEL_W-1:0]  ls_wr_sel,
    output logic [DATA_W-1:0]  ls_wr_data,
    output logic               ls_fill_en,
    output logic [TAG_W-1:0]   ls_fill_tag,
    output logic [LINE_W-1:0]  ls_fill_line,
    output logic               wb_push,
    output logic [BADDR_W-1:0] wb_push_baddr,
    output logic [LINE_W-1:0]  wb_push_line,
    input  logic               wb_full,
    output logic [BADDR_W-1:0] wb_lk_baddr,
    input  logic               wb_lk_hit,
    input  logic [LINE_W-1:0]  wb_lk_line,
    output logic               mem_rd_valid,
    input  logic               mem_rd_ready,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic               mem_rvalid,
    input  logic [DATA_W-1:0]  mem_rdata
);

    ctrl_st_e          st_q, st_d;
    logic              q_we;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_wdata;
    logic [WSEL_W-1:0] beat_q;
    logic [DATA_W-1:0] fill_buf [WORDS];
    logic [LINE_W-1:0] fill_asm;

    logic [WSEL_W-1:0]  q_word;
    logic [IDX_W-1:0]   q_idx;
    logic [TAG_W-1:0]   q_tag;
    logic [BADDR_W-1:0] q_baddr;
    logic               hit, victim_dirty, last_beat;

    assign q_word  = q_addr[OFF_W-1:BYTE_W];
    assign q_idx   = q_addr[OFF_W +: IDX_W];
    assign q_tag   = q_addr[ADDR_W-1 -: TAG_W];
    assign q_baddr = q_addr[ADDR_W-1:OFF_W];

    assign hit          = ls_valid && (ls_tag == q_tag);
    assign victim_dirty = ls_valid && ls_dirty;
    assign last_beat    = (beat_q == WSEL_W'(WORDS - 1));

    assign ls_idx        = q_idx;
    assign ls_wr_sel     = q_word;
    assign ls_wr_data    = q_wdata;
    assign ls_fill_tag   = q_tag;
    assign wb_push_baddr = {ls_tag, q_idx};
    assign wb_push_line  = ls_line;
    assign wb_lk_baddr   = q_baddr;
    assign req_ready     = (st_q == ST_IDLE);
    assign mem_rd_valid  = (st_q == ST_MREQ);
    assign mem_rd_addr   = {q_baddr, OFF_W'(0)};
    assign rsp_rdata     = ls_line[q_word*DATA_W +: DATA_W];

    // Block assembled from earlier beats plus the beat arriving now
    always_comb begin
        for (int w = 0; w < WORDS; w++) begin
            fill_asm[w*DATA_W +: DATA_W] =
                (beat_q == WSEL_W'(w)) ? mem_rdata : fill_buf[w];
        end
    end

    always_comb begin
        st_d         = st_q;
        rsp_valid    = 1'b0;
        ls_wr_en     = 1'b0;
        ls_fill_en   = 1'b0;
        ls_fill_line = wb_lk_line;
        wb_push      = 1'b0;
        case (st_q)
            ST_IDLE: if (req_valid) st_d = ST_LOOK;
            ST_LOOK: begin
                if (hit) begin
                    rsp_valid = 1'b1;
                    ls_wr_en  = q_we;
                    st_d      = ST_IDLE;
                end else if (!(victim_dirty && wb_full)) begin
                    wb_push = victim_dirty;
                    if (wb_lk_hit) begin
                        ls_fill_en = 1'b1;   // replay lookup next cycle
                    end else begin
                        st_d = ST_MREQ;
                    end
                end
            end
            ST_MREQ: if (mem_rd_ready) st_d = ST_FILL;
            ST_FILL: begin
                ls_fill_line = fill_asm;
                if (mem_rvalid && last_beat) begin
                    ls_fill_en = 1'b1;
                    st_d       = ST_LOOK;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            beat_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_MREQ) begin
                beat_q <= '0;
            end else if (st_q == ST_FILL && mem_rvalid) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (st_q == ST_IDLE && req_valid) begin
            q_we    <= req_we;
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
        end
        if (st_q == ST_FILL && mem_rvalid) begin
            fill_buf[beat_q] <= mem_rdata;
        end
    end

endmodule

// File: rtl/dwb_cache.sv
module dwb_cache
    import dwbc_pkg::*;
#(
    parameter  int ADDR_W  = DEF_ADDR_W,
    parameter  int DATA_W  = DEF_DATA_W,
    parameter  int LINES   = DEF_LINES,
    parameter  int WORDS   = DEF_WORDS,
    parameter  int WBDEPTH = DEF_WBDEPTH,
    localparam int BYTE_W  = $clog2(DATA_W / 8),
    localparam int WSEL_W  = $clog2(WORDS),
    localparam int OFF_W   = BYTE_W + WSEL_W,
    localparam int IDX_W   = $clog2(LINES),
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
    localparam int BADDR_W = ADDR_W - OFF_W,
    localparam int LINE_W  = WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_wvalid,
    input  logic              mem_wready,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wlast
);

    logic [IDX_W-1:0]   ls_idx;
    logic               ls_valid, ls_dirty, ls_wr_en, ls_fill_en;
    logic [TAG_W-1:0]   ls_tag, ls_fill_tag;
    logic [LINE_W-1:0]  ls_line, ls_fill_line;
    logic [WSEL_W-1:0]  ls_wr_sel;
    logic [DATA_W-1:0]  ls_wr_data;
    logic               wb_push, wb_full, wb_lk_hit;
    logic [BADDR_W-1:0] wb_push_baddr, wb_lk_baddr;
    logic [LINE_W-1:0]  wb_push_line, wb_lk_line;

    dwbc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_we       (req_we),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .ls_idx       (ls_idx),
        .ls_valid     (ls_valid),
        .ls_dirty     (ls_dirty),
        .ls_tag       (ls_tag),
        .ls_line      (ls_line),
        .ls_wr_en     (ls_wr_en),
        .ls_wr_sel    (ls_wr_sel),
        .ls_wr_data   (ls_wr_data),
        .ls_fill_en   (ls_fill_en),
        .ls_fill_tag  (ls_fill_tag),
        .ls_fill_line (ls_fill_line),
        .wb_push      (wb_push),
        .wb_push_baddr(wb_push_baddr),
        .wb_push_line (wb_push_line),
        .wb_full      (wb_full),
        .wb_lk_baddr  (wb_lk_baddr),
        .wb_lk_hit    (wb_lk_hit),
        .wb_lk_line   (wb_lk_line),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata)
    );

    dwbc_line_store #(
        .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)
    ) u_lines (
        .clk      (clk),
        .rst      (rst),
        .idx      (ls_idx),
        .rd_valid (ls_valid),
        .rd_dirty (ls_dirty),
        .rd_tag   (ls_tag),
        .rd_line  (ls_line),
        .wr_en    (ls_wr_en),
        .wr_sel   (ls_wr_sel),
        .wr_data  (ls_wr_data),
        .fill_en  (ls_fill_en),
        .fill_tag (ls_fill_tag),
        .fill_line(ls_fill_line)
    );

    dwbc_wbuf #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .DEPTH(WBDEPTH)
    ) u_wbuf (
        .clk       (clk),
        .rst       (rst),
        .push      (wb_push),
        .push_baddr(wb_push_baddr),
        .push_line (wb_push_line),
        .full      (wb_full),
        .lk_baddr  (wb_lk_baddr),
        .lk_hit    (wb_lk_hit),
        .lk_line   (wb_lk_line),
        .mem_wvalid(mem_wvalid),
        .mem_wready(mem_wready),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_wlast (mem_wlast)
    );

endmodule

// File: rtl/dwb_cache_chk.sv
module dwb_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_wvalid,
    input logic              mem_wready,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic [DATA_W-1:0] mem_wdata
);

    // R1: reset leaves the ports quiet and ready
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_valid && !mem_rd_valid && !mem_wvalid));

    // R5: a read request holds steady until accepted
    p_rd_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R5: read requests are block aligned
    p_rd_align_r5: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> (mem_rd_addr[OFF_W-1:0] == '0));

    // R7: a writeback beat holds steady until accepted
    p_wb_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_wvalid && !mem_wready) |=>
            (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));

    // R8: an accepted request blocks the next cycle
    p_two_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R4: a completed access returns the port to ready
    p_done_ready_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> req_ready);

    // R4: no completion while idle
    p_no_idle_rsp_r4: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !rsp_valid);

endmodule

bind dwb_cache dwb_cache_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr (mem_rd_addr),
    .mem_wvalid  (mem_wvalid),
    .mem_wready  (mem_wready),
    .mem_waddr   (mem_waddr),
    .mem_wdata   (mem_wdata)
);

// File: tb/dwb_cache_tb.sv
`timescale 1ns/1ps
module dwb_cache_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_we;
    logic [31:0] req_addr, req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_rd_valid, mem_rd_ready;
    logic [31:0] mem_rd_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        mem_wvalid, mem_wready, mem_wlast;
    logic [31:0] mem_waddr, mem_wdata;

    always #4 clk = ~clk;   // 125 MHz

    dwb_cache u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .mem_wlast(mem_wlast)
    );

    int n_chk = 0, n_bad = 0;
    int rd_count = 0, wr_beats = 0, wlast_err = 0, wbeat = 0;
    logic [31:0] mem_m [logic [31:0]];
    logic [31:0] sh_m  [logic [31:0]];

    function automatic logic [31:0] init_val(logic [31:0] a);
        return {a[15:0] ^ 16'h3C3C, ~a[15:0]};
    endfunction
    function automatic logic [31:0] mem_get(logic [31:0] a);
        return mem_m.exists(a) ? mem_m[a] : init_val(a);
    endfunction
    function automatic logic [31:0] sh_get(logic [31:0] a);
        return sh_m.exists(a) ? sh_m[a] : init_val(a);
    endfunction

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", what, act, exp);
        end
    endtask

    // Memory-side monitor: counts reads, stores writeback beats
    always @(posedge clk) begin
        if (!rst) begin
            if (mem_rd_valid && mem_rd_ready) rd_count++;
            if (mem_wvalid && mem_wready) begin
                mem_m[mem_waddr] = mem_wdata;
                wr_beats++;
                if (mem_wlast !== (wbeat == 3)) wlast_err++;
                if (mem_waddr[3:2] != wbeat[1:0]) wlast_err++;
                wbeat = (wbeat == 3) ? 0 : wbeat + 1;
            end
        end
    end

    // Refill responder: four beats, ascending words
    initial begin
        mem_rd_ready = 1'b1;
        mem_rvalid   = 1'b0;
        mem_rdata    = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (mem_rd_valid) begin
                logic [31:0] base;
                base = mem_rd_addr;
                for (int b = 0; b < 4; b++) begin
                    @(negedge clk);
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem_get(base + 32'(4 * b));
                end
            end
        end
    end

    task automatic issue(input logic we, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic await_rsp(input int limit, output logic got,
                             output logic [31:0] rd, output int lat);
        got = 1'b0; rd = '0; lat = 1;
        forever begin
            if (rsp_valid) begin
                got = 1'b1; rd = rsp_rdata; return;
            end
            if (lat >= limit) return;
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int lat);
        logic got;
        issue(we, a, d);
        await_rsp(300, got, rd, lat);
        check("R5 access completes", {31'b0, got}, 32'd1);
        if (we) sh_m[a] = d;
    endtask

    // Vector: {store, expect_hit, address}
    localparam int NV = 16;
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 1'b0, 32'h0000_0000},  // cold miss, tag matches reset tag
        {1'b0, 1'b1, 32'h0000_000C},  // same block
        {1'b1, 1'b1, 32'h0000_0008},  // store hit
        {1'b0, 1'b1, 32'h0000_0008},
        {1'b0, 1'b0, 32'h0000_0084},  // same index, new tag, dirty victim
        {1'b0, 1'b0, 32'h0000_0008},  // clean victim
        {1'b1, 1'b0, 32'h0000_0094},  // store miss allocates
        {1'b0, 1'b1, 32'h0000_0094},
        {1'b0, 1'b0, 32'h0000_0014},  // dirty victim
        {1'b0, 1'b0, 32'h0000_0090},
        {1'b0, 1'b1, 32'h0000_0094},  // data survived writeback
        {1'b1, 1'b0, 32'h0000_00F0},
        {1'b1, 1'b1, 32'h0000_00FC},
        {1'b0, 1'b0, 32'h0000_0070},  // dirty victim
        {1'b0, 1'b0, 32'h0000_00F0},
        {1'b0, 1'b1, 32'h0000_00FC}
    };

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd, d1, d2, d3;
        int lat, rc, wb;
        logic got;
        rst = 1'b1; req_valid = 1'b0; req_we = 1'b0;
        req_addr = '0; req_wdata = '0; mem_wready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset req_ready", {31'b0, req_ready}, 32'd1);
        check("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check("R1 reset mem_rd_valid", {31'b0, mem_rd_valid}, 32'd0);
        check("R1 reset mem_wvalid", {31'b0, mem_wvalid}, 32'd0);

        // Table walk: R2 R3 R4 R5 R8 hit/miss class and data
        for (int i = 0; i < NV; i++) begin
            logic we, eh;
            logic [31:0] a, d;
            we = VEC[i][33]; eh = VEC[i][32]; a = VEC[i][31:0];
            d  = 32'hC0DE_0000 | 32'(i);
            access(we, a, d, rd, lat);
            check($sformatf("R2 R3 R4 R8 hit class vec %0d lat %0d", i, lat),
                  {31'b0, lat == 1}, {31'b0, eh});
            if (!we) check($sformatf("R5 load data vec %0d", i), rd, sh_get(a));
        end
        repeat (12) @(negedge clk);
        check("R5 one read burst per miss", 32'(rd_count), 32'd9);
        check("R7 writeback beats for three dirty victims", 32'(wr_beats), 32'd12);
        check("R7 beat order and last flag", 32'(wlast_err), 32'd0);
        check("R7 memory word 0x08", mem_get(32'h08), 32'hC0DE_0002);
        check("R7 memory word 0x94", mem_get(32'h94), 32'hC0DE_0006);
        check("R7 memory word 0xFC", mem_get(32'hFC), 32'hC0DE_000C);

        // R6: store hit touches only the cache
        wb = wr_beats; rc = rd_count;
        access(1'b1, 32'hF8, 32'h5555_AAAA, rd, lat);
        repeat (10) @(negedge clk);
        check("R6 store hit latency", 32'(lat), 32'd1);
        check("R6 no writeback on store hit", 32'(wr_beats), 32'(wb));
        check("R6 memory unchanged", mem_get(32'hF8), init_val(32'hF8));
        access(1'b0, 32'hF8, 32'h0, rd, lat);
        check("R6 cached store visible", rd, 32'h5555_AAAA);

        // R9 R10: fill the write buffer with the drain held off
        mem_wready = 1'b0;
        d1 = 32'h1111_0020; d2 = 32'h2222_0030; d3 = 32'h3333_0040;
        access(1'b1, 32'h20, d1, rd, lat);
        access(1'b1, 32'h30, d2, rd, lat);
        access(1'b1, 32'h40, d3, rd, lat);
        access(1'b0, 32'hA0, 32'h0, rd, lat);
        access(1'b0, 32'hB0, 32'h0, rd, lat);
        wb = wr_beats;
        rc = rd_count;
        access(1'b0, 32'h20, 32'h0, rd, lat);
        check("R10 load served from buffer", rd, d1);
        check("R10 no memory read", 32'(rd_count), 32'(rc));
        access(1'b0, 32'h54, 32'h0, rd, lat);
        check("R9 clean miss proceeds while full", rd, init_val(32'h54));
        rc = rd_count;
        issue(1'b0, 32'hC0, 32'h0);
        await_rsp(20, got, rd, lat);
        check("R9 dirty eviction stalls when full", {31'b0, got}, 32'd0);
        check("R9 no read while stalled", 32'(rd_count), 32'(rc));
        mem_wready = 1'b1;
        await_rsp(300, got, rd, lat);
        check("R9 stalled load completes", {31'b0, got}, 32'd1);
        check("R9 stalled load data", rd, init_val(32'hC0));
        repeat (20) @(negedge clk);
        check("R7 three blocks drained", 32'(wr_beats), 32'(wb + 12));
        check("R7 drained word 0x30", mem_get(32'h30), d2);
        check("R7 drained word 0x40", mem_get(32'h40), d3);

        // R1: reset in mid-run invalidates every line
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        check("R1 ready after reset", {31'b0, req_ready}, 32'd1);
        rc = rd_count;
        access(1'b0, 32'h20, 32'h0, rd, lat);
        check("R1 first access after reset misses", {31'b0, lat > 1}, 32'd1);
        check("R1 data refetched from memory", rd, d1);
        check("R1 one read after reset", 32'(rd_count), 32'(rc + 1));

        finish_run();
    end

endmodule